// File: doc/BRIEF.md
# Dual-Address I2C Slave Byte Engine

This block is the byte-level slave side of a two-wire serial bus port. It takes SCL and SDA inputs that are already synchronised to the system clock, detects bus framing events (START, repeated START, STOP) and shifts the first byte after each START into an 8-bit shift register. The upper seven bits of that byte are compared against two independently programmable 7-bit slave addresses. If either address matches, the engine acknowledges and then moves data bytes in the direction given by the low bit of the address byte. A small identifier output reports which of the two addresses was hit.

Received bytes are copied from the shift register into a separate data register and announced to the host with a one-clock strobe. For transmit, the engine holds SCL low and raises a request until the host presents the next byte with a one-clock valid strobe, then shifts that byte out MSB first. Both bus outputs are open-drain style: 0 pulls the wire low, 1 releases it.

The controller is a single state machine with nine states. `ST_IDLE` waits for a START. `ST_ADDR` gathers the address byte. On the SCL falling edge after the eighth bit it goes to `ST_ADDR_ACK` on a match or to `ST_IGNORE` otherwise. `ST_ADDR_ACK` leaves on the next SCL fall: to `ST_TX_WAIT` when the direction bit is 1, or to `ST_RX` when it is 0. `ST_RX` goes to `ST_RX_ACK` after eight bits, and `ST_RX_ACK` returns to `ST_RX` on the following fall. `ST_TX_WAIT` goes to `ST_TX` when the host strobes `tx_valid`. `ST_TX` goes to `ST_TX_ACK` after eight bits. `ST_TX_ACK` returns to `ST_TX_WAIT` if the master acknowledged, or goes to `ST_IGNORE` if it did not. From every state a STOP leads to `ST_IDLE` and a START leads to `ST_ADDR`, and STOP takes precedence.

Top module: `i2cs_dual_slave`

## Requirements
- R1: A START or repeated START (SDA falling while SCL stays high) from any state restarts byte framing, so the next eight SCL pulses are taken as a fresh address byte.
- R2: A STOP (SDA rising while SCL stays high) returns the engine to idle, releases SDA and clears `match_id` to 0 one clock after it is seen.
- R3: The address byte is received MSB first. Its bits 7..1 form the 7-bit address and its bit 0 sets the direction: 1 means the slave transmits, 0 means the slave receives.
- R4: When the received address equals `addr_a` or `addr_b`, SDA is pulled low for the whole ninth SCL pulse and released after that pulse's falling edge.
- R5: When neither address matches, SDA stays released, and `rx_valid` and `tx_req` stay low, until the next START or STOP.
- R6: `match_id` becomes 1 for a hit on `addr_a` and 2 for a hit on `addr_b`. If both registers hold the same value, 1 wins. The value is held until STOP and is never 3.
- R7: In receive mode each data byte is shifted in MSB first and acknowledged. `rx_data` carries the byte and `rx_valid` pulses for exactly one clock, one clock after the SCL fall that ends the eighth bit.
- R8: Before each transmitted byte the engine asserts `tx_req` and holds `scl_o` low until `tx_valid` is strobed. It then loads `tx_data` and drives it MSB first.
- R9: In transmit mode an ACK (SDA low) from the master on the ninth bit leads to a request for the next byte. A NACK (SDA high) releases SDA with no further requests until the next START or STOP.
- R10: `sda_o` only changes while SCL is low, except when it is released at a START or STOP.
- R11: After reset `sda_o` and `scl_o` are 1, `match_id` is 0, and `tx_req` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL wire level |
| sda_i | input | 1 | Synchronised SDA wire level |
| scl_o | output | 1 | SCL open-drain drive (0 stretches the clock) |
| sda_o | output | 1 | SDA open-drain drive (0 pulls low) |
| addr_a | input | 7 | First programmable slave address |
| addr_b | input | 7 | Second programmable slave address |
| match_id | output | 2 | 0 none, 1 first address hit, 2 second address hit |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-clock strobe: `rx_data` holds a new byte |
| tx_req | output | 1 | Engine is waiting for the next byte to send |
| tx_valid | input | 1 | One-clock strobe: `tx_data` is ready |
| tx_data | input | 8 | Byte to send |

## Verification
All results of this block are registered one clock after the bus event that causes them. The ACK pull-down, the SDA release, `rx_valid`, `match_id` and `tx_req` all follow the SCL falling edge by one clock, a STOP clears `match_id` one clock later, and a transmitted bit appears one clock after the fall or the `tx_valid` strobe. The bench drives the bus from the falling edge of the system clock and keeps each SCL phase four clocks long. Every check is therefore taken at a falling clock edge at least two clocks after the event that settles it, so each value is read after it has settled and before the next SCL edge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int SLOTS  = 2;
    localparam int ID_W   = $clog2(SLOTS + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX_WAIT,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } i2cs_state_e;

endpackage

// File: rtl/i2cs_line_mon.sv
// Detects SCL edges and START/STOP framing from synchronised bus levels.
module i2cs_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_d;
    assign scl_fall  = ~scl_i & scl_d;
    assign start_det = scl_i & scl_d & sda_d & ~sda_i;
    assign stop_det  = scl_i & scl_d & ~sda_d & sda_i;

endmodule

// File: rtl/i2cs_addr_cmp.sv
// Compares a received address against NS programmable slots; lowest slot wins.
module i2cs_addr_cmp #(
    parameter int AW = 7,
    parameter int NS = 2,
    parameter int IW = $clog2(NS + 1)
) (
    input  logic [AW-1:0]         rx_addr,
    input  logic [NS-1:0][AW-1:0] slot_addr,
    output logic [IW-1:0]         hit_id
);

    logic [NS-1:0] hit;

    generate
        for (genvar g = 0; g < NS; g++) begin : g_slot
            assign hit[g] = (rx_addr == slot_addr[g]);
        end
    endgenerate

    always_comb begin
        hit_id = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (hit[i]) hit_id = IW'(i + 1);
        end
    end

endmodule

// File: rtl/i2cs_dual_slave.sv
module i2cs_dual_slave
    import i2cs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int IW = ID_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_o,
    output logic          sda_o,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output logic [IW-1:0] match_id,
    output logic [BW-1:0] rx_data,
    output logic          rx_valid,
    output logic          tx_req,
    input  logic          tx_valid,
    input  logic [BW-1:0] tx_data
);

    localparam int            CW   = $clog2(BW + 1);
    localparam logic [CW-1:0] FULL = CW'(BW);

    i2cs_state_e state, nxt;

    logic          scl_rise, scl_fall, start_det, stop_det;
    logic [BW-1:0] shreg;
    logic [CW-1:0] bit_cnt;
    logic          sda_q;
    logic          acked;
    logic [IW-1:0] hit_id;
    logic [IW-1:0] match_q;
    logic [BW-1:0] rx_q;
    logic          rx_stb;
    logic          cnt_full;

    assign cnt_full = (bit_cnt == FULL);

    i2cs_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_addr_cmp #(.AW(AW), .NS(SLOTS), .IW(IW)) u_cmp (
        .rx_addr   (shreg[BW-1 -: AW]),
        .slot_addr ({addr_b, addr_a}),
        .hit_id    (hit_id)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && cnt_full)
                                 nxt = (hit_id != '0) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = shreg[0] ? ST_TX_WAIT : ST_RX;
                ST_RX:       if (scl_fall && cnt_full) nxt = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) nxt = ST_RX;
                ST_TX_WAIT:  if (tx_valid) nxt = ST_TX;
                ST_TX:       if (scl_fall && cnt_full) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = acked ? ST_TX_WAIT : ST_IGNORE;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        scl_o  = 1'b1;
        tx_req = 1'b0;
        if (state == ST_TX_WAIT) begin
            scl_o  = 1'b0;
            tx_req = 1'b1;
        end
    end

    // Shift register, bit counter and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            sda_q   <= 1'b1;
            acked   <= 1'b0;
            match_q <= '0;
            rx_q    <= '0;
            rx_stb  <= 1'b0;
        end else begin
            rx_stb <= 1'b0;
            if (stop_det) begin
                sda_q   <= 1'b1;
                bit_cnt <= '0;
                match_q <= '0;
            end else if (start_det) begin
                sda_q   <= 1'b1;
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BW-2:0], sda_i};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && cnt_full) begin
                            if (state == ST_ADDR) begin
                                if (hit_id != '0) begin
                                    sda_q   <= 1'b0;
                                    match_q <= hit_id;
                                end
                            end else begin
                                rx_q   <= shreg;
                                rx_stb <= 1'b1;
                                sda_q  <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_q   <= 1'b1;
                            bit_cnt <= '0;
                        end
                    end
                    ST_TX_WAIT: begin
                        if (tx_valid) begin
                            shreg   <= tx_data;
                            sda_q   <= tx_data[BW-1];
                            bit_cnt <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (cnt_full) begin
                                sda_q <= 1'b1;
                            end else begin
                                shreg <= {shreg[BW-2:0], 1'b0};
                                sda_q <= shreg[BW-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) acked <= ~sda_i;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_o    = sda_q;
    assign match_id = match_q;
    assign rx_data  = rx_q;
    assign rx_valid = rx_stb;

endmodule

// File: rtl/i2cs_dual_slave_chk.sv
module i2cs_dual_slave_chk
    import i2cs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input i2cs_state_e state,
    input logic        sda_o,
    input logic        scl_i,
    input logic        tx_req,
    input logic        rx_valid,
    input logic [1:0]  match_id,
    input logic        start_det,
    input logic        stop_det
);

    p_stop_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (match_id == 2'd0 && state == ST_IDLE));

    p_ack_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_RX_ACK) |-> !sda_o);

    p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (sda_o && !tx_req && !rx_valid));

    p_id_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_id));

    p_rx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !scl_i);

    p_sda_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(start_det) && !$past(stop_det))
            |-> $stable(sda_o));

endmodule

bind i2cs_dual_slave i2cs_dual_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .sda_o     (sda_o),
    .scl_i     (scl_i),
    .tx_req    (tx_req),
    .rx_valid  (rx_valid),
    .match_id  (match_id),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2cs_dual_slave_tb.sv
module i2cs_dual_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam logic [6:0] ADR_A = 7'h2A;
    localparam logic [6:0] ADR_B = 7'h51;

    // {address[6:0], dir, data[7:0], expected id[1:0]}
    localparam logic [17:0] VEC [0:7] = '{
        {7'h2A, 1'b0, 8'hA5, 2'd1},
        {7'h51, 1'b0, 8'h3C, 2'd2},
        {7'h2A, 1'b1, 8'h96, 2'd1},
        {7'h51, 1'b1, 8'h0F, 2'd2},
        {7'h13, 1'b0, 8'hFF, 2'd0},
        {7'h13, 1'b1, 8'h55, 2'd0},
        {7'h51, 1'b0, 8'h00, 2'd2},
        {7'h2A, 1'b1, 8'h80, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_scl = 1'b1;
    logic       ms_sda = 1'b1;
    logic       scl_o, sda_o;
    logic       scl_line, sda_line;
    logic [6:0] addr_a = ADR_A;
    logic [6:0] addr_b = ADR_B;
    logic [1:0] match_id;
    logic [7:0] rx_data;
    logic       rx_valid, tx_req;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;

    int         n_tests = 0;
    int         n_fail  = 0;
    int         rx_count = 0;
    logic [7:0] rx_last = 8'h00;
    int         r10_viol = 0;
    logic       prev_scl = 1'b1;
    logic       prev_sda = 1'b1;
    bit         done = 1'b0;

    assign scl_line = ms_scl & scl_o;
    assign sda_line = ms_sda & sda_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2cs_dual_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_line),
        .sda_i    (sda_line),
        .scl_o    (scl_o),
        .sda_o    (sda_o),
        .addr_a   (addr_a),
        .addr_b   (addr_b),
        .match_id (match_id),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_req   (tx_req),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    // Port observers
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                rx_count = rx_count + 1;
                rx_last  = rx_data;
            end
            if (scl_line && prev_scl && (sda_o !== prev_sda)) r10_viol = r10_viol + 1;
        end
        prev_scl = scl_line;
        prev_sda = sda_o;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        ms_sda = 1'b1; step(Q);
        ms_scl = 1'b1; step(Q);
        ms_sda = 1'b0; step(Q);
        ms_scl = 1'b0; step(2);
    endtask

    task automatic bus_stop();
        ms_sda = 1'b0; step(Q);
        ms_scl = 1'b1; step(Q);
        ms_sda = 1'b1; step(Q);
    endtask

    task automatic send_bit(input logic b);
        ms_sda = b;    step(Q);
        ms_scl = 1'b1; step(Q);
        ms_scl = 1'b0; step(2);
    endtask

    task automatic get_bit(output logic b);
        ms_sda = 1'b1; step(Q);
        ms_scl = 1'b1; step(Q);
        b = sda_line;
        ms_scl = 1'b0; step(2);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
    endtask

    task automatic supply(input logic [7:0] v);
        tx_data  = v;
        tx_valid = 1'b1;
        step(1);
        tx_valid = 1'b0;
    endtask

    task automatic run_xfer(input logic [6:0] a, input logic rw, input logic [7:0] d,
                            input logic [1:0] id);
        int         rc0;
        logic       ackb;
        logic [7:0] got;
        rc0 = rx_count;
        bus_start();
        send_byte({a, rw});
        get_bit(ackb);
        chk("R4 address ack", ackb, (id != 2'd0) ? 1'b0 : 1'b1);
        chk("R6 match id", match_id, id);
        if (!rw) begin
            send_byte(d);
            get_bit(ackb);
            if (id != 2'd0) begin
                chk("R7 data ack", ackb, 1'b0);
                chk("R7 rx byte", rx_last, d);
                chk("R7 rx count", rx_count, rc0 + 1);
            end else begin
                chk("R5 no data ack", ackb, 1'b1);
                chk("R5 no rx strobe", rx_count, rc0);
            end
        end else begin
            if (id != 2'd0) begin
                step(2);
                chk("R8 tx request", tx_req, 1'b1);
                ms_scl = 1'b1; step(2);
                chk("R8 scl held low", scl_line, 1'b0);
                ms_scl = 1'b0; step(1);
                supply(d);
            end else begin
                chk("R5 no tx request", tx_req, 1'b0);
            end
            get_byte(got);
            chk("R8 tx byte", got, (id != 2'd0) ? d : 8'hFF);
            send_bit(1'b1);
            chk("R9 released after nack", sda_o, 1'b1);
            chk("R9 no request after nack", tx_req, 1'b0);
        end
        chk("R6 id held", match_id, id);
        bus_stop();
        step(1);
        chk("R2 id cleared", match_id, 2'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic       b;
        logic [7:0] got;
        int         rc0;

        step(3);
        // R11 reset state
        chk("R11 sda_o", sda_o, 1'b1);
        chk("R11 scl_o", scl_o, 1'b1);
        chk("R11 match_id", match_id, 2'd0);
        chk("R11 tx_req", tx_req, 1'b0);
        chk("R11 rx_valid", rx_valid, 1'b0);
        rst_n = 1'b1;
        step(4);

        // Table of transfers (R3 framing of address and direction bit)
        for (int i = 0; i < 8; i++) begin
            run_xfer(VEC[i][17:11], VEC[i][10], VEC[i][9:2], VEC[i][1:0]);
        end

        // R6: equal addresses, first register wins
        addr_b = ADR_A;
        run_xfer(ADR_A, 1'b0, 8'h5A, 2'd1);
        addr_b = ADR_B;

        // R1: repeated START switches to the second address
        rc0 = rx_count;
        bus_start();
        send_byte({ADR_A, 1'b0});
        get_bit(b);
        send_byte(8'hC3);
        get_bit(b);
        chk("R1 first byte", rx_last, 8'hC3);
        bus_start();
        send_byte({ADR_B, 1'b0});
        get_bit(b);
        chk("R1 restart ack", b, 1'b0);
        chk("R6 id after restart", match_id, 2'd2);
        send_byte(8'h7E);
        get_bit(b);
        chk("R1 second byte", rx_last, 8'h7E);
        chk("R7 two strobes", rx_count, rc0 + 2);
        bus_stop();
        step(1);

        // R9: two-byte read, ACK then NACK
        bus_start();
        send_byte({ADR_B, 1'b1});
        get_bit(b);
        step(1);
        supply(8'hE1);
        get_byte(got);
        chk("R9 first read", got, 8'hE1);
        send_bit(1'b0);
        chk("R9 request after ack", tx_req, 1'b1);
        supply(8'h1E);
        get_byte(got);
        chk("R9 second read", got, 8'h1E);
        send_bit(1'b1);
        get_bit(b);
        chk("R9 line released", b, 1'b1);
        chk("R9 no request", tx_req, 1'b0);
        bus_stop();
        step(1);

        // R1/R2: STOP in the middle of an address byte, then a clean write
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(ADR_A[6 - i]);
        bus_stop();
        step(1);
        chk("R2 mid-byte stop", match_id, 2'd0);
        chk("R2 sda released", sda_o, 1'b1);
        run_xfer(ADR_B, 1'b0, 8'h99, 2'd2);

        chk("R10 sda stable while scl high", r10_viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule